// File: doc/BRIEF.md
# Two-dimensional strided address generator

This block sits on the memory-facing side of a DMA channel. It takes one descriptor, which holds a start address, a per-line byte count, a line count and a line-to-line stride. From it the block emits a stream of bus-beat addresses, with a marker on the final beat. The data path that moves the bytes consumes the stream through a valid/ready pair. Bus protocol handling and data movement belong to other blocks.

Both lengths arrive stored minus one. Each line is walked at the configured bus width, so every beat advances the address by the bus width in bytes. The next line starts one stride after the start of the line before it, which lets the stride describe a gap between lines.

When the descriptor is not cyclic, the block gives a one-cycle done pulse after the final beat and goes back to idle. When it is cyclic, the block starts the same pattern again from the original address and gives no done pulse. Only a reset ends a cyclic run.

Top module: `stride2d_agen`

## Requirements
- R1: After reset, desc_ready is 1, out_valid is 0 and done is 0.
- R2: A descriptor is taken only when the block is idle. While a descriptor is running, desc_ready is 0, and the values on the descriptor inputs have no effect on the address stream.
- R3: The first beat address equals the start address. Each following beat in the same line is the previous beat address plus BUS_BYTES.
- R4: Each line has (xlen >> log2(BUS_BYTES)) + 1 beats, which covers xlen+1 bytes. There are ylen+1 lines, so a frame has beats-per-line times (ylen+1) beats.
- R5: The first beat of each line after the first is at the previous line's first-beat address plus the stride.
- R6: out_last is 1 on the final beat of the final line of a frame, and 0 on every other beat.
- R7: For a non-cyclic descriptor, done is 1 for exactly one cycle, in the cycle after the final beat's handshake. In that cycle out_valid is 0 and desc_ready is 1.
- R8: For a cyclic descriptor (desc_cyclic = 1), the beat after a frame's final beat is at the start address again. The stream goes on without a break, and done stays 0.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_addr and out_last hold their values.
- R10: The low log2(BUS_BYTES) bits of desc_addr and desc_stride are ignored and treated as zero, so every out_addr is aligned to BUS_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | A descriptor is offered |
| desc_ready | output | 1 | Block is idle and will take a descriptor |
| desc_addr | input | ADDR_W | Start byte address |
| desc_xlen | input | LEN_W | Bytes per line minus one |
| desc_ylen | input | LEN_W | Lines minus one |
| desc_stride | input | ADDR_W | Byte distance between line starts |
| desc_cyclic | input | 1 | Repeat the frame without end |
| out_valid | output | 1 | A beat address is offered |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | ADDR_W | Beat byte address |
| out_last | output | 1 | Final beat of the frame |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- the exclusion between desc_ready and out_valid;
- the hold rule under backpressure;
- address alignment;
- the single-cycle done pulse after a non-cyclic last beat;
- the absence of done during a cyclic run.

Other behaviour is visible only through the bench's directed scenarios, which compare every beat against addresses the bench computes itself. These scenarios cover:
- the exact address sequence and the stride step between lines;
- the beat count per line;
- the placement of out_last;
- the wrap back to the start address in cyclic mode;
- the way descriptor inputs offered while busy are ignored.

// File: rtl/stride2d_agen_pkg.sv
package stride2d_agen_pkg;

    typedef enum logic [0:0] {
        AG_IDLE = 1'b0,
        AG_RUN  = 1'b1
    } agen_state_e;

    // Number of low address bits covered by one bus beat.
    function automatic int unsigned beat_shift(input int unsigned bytes);
        return $clog2(bytes);
    endfunction

endpackage

// File: rtl/stride2d_agen_cnt.sv
// Wrapping counter: counts 0..limit, then wraps to zero on the next step.
module stride2d_agen_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_limit
);
    logic [W-1:0] cnt_q;

    assign at_limit = (cnt_q == limit);
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_limit ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/stride2d_agen_desc.sv
// Captures the accepted descriptor, with the sub-beat address bits cleared.
module stride2d_agen_desc #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_xlen,
    input  logic [LEN_W-1:0]  in_ylen,
    input  logic [ADDR_W-1:0] in_stride,
    input  logic              in_cyclic,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] stride,
    output logic [LEN_W-1:0]  beats_m1,
    output logic [LEN_W-1:0]  lines_m1,
    output logic              cyclic
);
    import stride2d_agen_pkg::*;

    localparam int unsigned SH = beat_shift(BUS_BYTES);
    localparam logic [ADDR_W-1:0] SUB_MASK = ADDR_W'(BUS_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stride;
        logic [LEN_W-1:0]  beats_m1;
        logic [LEN_W-1:0]  lines_m1;
        logic              cyclic;
    } desc_t;

    desc_t cur_q;
    desc_t nxt;

    always_comb begin
        nxt.start    = in_addr & ~SUB_MASK;
        nxt.stride   = in_stride & ~SUB_MASK;
        nxt.beats_m1 = in_xlen >> SH;
        nxt.lines_m1 = in_ylen;
        nxt.cyclic   = in_cyclic;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= nxt;
        end
    end

    assign start_addr = cur_q.start;
    assign stride     = cur_q.stride;
    assign beats_m1   = cur_q.beats_m1;
    assign lines_m1   = cur_q.lines_m1;
    assign cyclic     = cur_q.cyclic;
endmodule

// File: rtl/stride2d_agen_addr.sv
// Address datapath: a line base register plus a running beat address.
module stride2d_agen_addr #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              line_end,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] next_line;

    always_comb begin
        next_line = wrap ? start_addr : base_q + stride;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= load_addr;
            cur_q  <= load_addr;
        end else if (step) begin
            if (line_end) begin
                base_q <= next_line;
                cur_q  <= next_line;
            end else begin
                cur_q <= cur_q + ADDR_W'(BUS_BYTES);
            end
        end
    end

    assign addr = cur_q;
endmodule

// File: rtl/stride2d_agen.sv
module stride2d_agen #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_xlen,
    input  logic [LEN_W-1:0]  desc_ylen,
    input  logic [ADDR_W-1:0] desc_stride,
    input  logic              desc_cyclic,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_last,
    output logic              done
);
    import stride2d_agen_pkg::*;

    localparam logic [ADDR_W-1:0] SUB_MASK = ADDR_W'(BUS_BYTES - 1);

    agen_state_e       state_q;
    logic              done_q;
    logic              accept;
    logic              fire;
    logic              beat_end;
    logic              line_last;
    logic              frame_end;
    logic              cyc_q;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  beats_m1_q;
    logic [LEN_W-1:0]  lines_m1_q;
    logic [LEN_W-1:0]  beat_cnt;
    logic [LEN_W-1:0]  line_cnt;

    assign desc_ready = (state_q == AG_IDLE);
    assign out_valid  = (state_q == AG_RUN);
    assign accept     = desc_valid && desc_ready;
    assign fire       = out_valid && out_ready;
    assign frame_end  = beat_end && line_last;
    assign out_last   = out_valid && frame_end;
    assign done       = done_q;

    stride2d_agen_desc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)
    ) desc_i (
        .clk(clk), .rst(rst), .load(accept),
        .in_addr(desc_addr), .in_xlen(desc_xlen), .in_ylen(desc_ylen),
        .in_stride(desc_stride), .in_cyclic(desc_cyclic),
        .start_addr(start_q), .stride(stride_q),
        .beats_m1(beats_m1_q), .lines_m1(lines_m1_q), .cyclic(cyc_q)
    );

    stride2d_agen_cnt #(.W(LEN_W)) beat_cnt_i (
        .clk(clk), .rst(rst), .clear(accept), .step(fire),
        .limit(beats_m1_q), .count(beat_cnt), .at_limit(beat_end)
    );

    stride2d_agen_cnt #(.W(LEN_W)) line_cnt_i (
        .clk(clk), .rst(rst), .clear(accept), .step(fire && beat_end),
        .limit(lines_m1_q), .count(line_cnt), .at_limit(line_last)
    );

    stride2d_agen_addr #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) addr_i (
        .clk(clk), .rst(rst),
        .load(accept), .load_addr(desc_addr & ~SUB_MASK),
        .step(fire), .line_end(beat_end), .wrap(frame_end && cyc_q),
        .start_addr(start_q), .stride(stride_q), .addr(out_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= AG_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                AG_IDLE: if (accept) state_q <= AG_RUN;
                AG_RUN: begin
                    if (fire && frame_end && !cyc_q) begin
                        state_q <= AG_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= AG_IDLE;
            endcase
        end
    end

    // Counter values are exposed for the address datapath only through limits.
    logic unused_cnt;
    assign unused_cnt = ^{beat_cnt, line_cnt};
endmodule

// File: rtl/stride2d_agen_chk.sv
module stride2d_agen_chk #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              desc_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_last,
    input logic              done,
    input logic              cyc_q
);
    localparam logic [ADDR_W-1:0] SUB_MASK = ADDR_W'(BUS_BYTES - 1);

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (desc_ready && !out_valid && !done));

    // R2
    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        desc_ready |-> !out_valid);

    // R9
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_last)));

    // R10
    a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_addr & SUB_MASK) == '0));

    // R7
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && !cyc_q) |=> (done && desc_ready && !out_valid));

    // R7
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    a_r8_no_done_cyclic: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cyc_q) |-> !done);
endmodule

bind stride2d_agen stride2d_agen_chk #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)
) chk_i (
    .clk(clk), .rst(rst), .desc_ready(desc_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_last(out_last),
    .done(done), .cyc_q(cyc_q)
);

// File: tb/stride2d_agen_tb_top.sv
module stride2d_agen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int BB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [AW-1:0] desc_addr = '0;
    logic [LW-1:0] desc_xlen = '0;
    logic [LW-1:0] desc_ylen = '0;
    logic [AW-1:0] desc_stride = '0;
    logic          desc_cyclic = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_addr;
    logic          out_last;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride2d_agen #(.ADDR_W(AW), .LEN_W(LW), .BUS_BYTES(BB)) dut_i (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_xlen(desc_xlen), .desc_ylen(desc_ylen),
        .desc_stride(desc_stride), .desc_cyclic(desc_cyclic),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_last(out_last), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; desc_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Offer a descriptor at a negedge; it is taken at the following posedge.
    task automatic send(input logic [AW-1:0] a, input logic [LW-1:0] x,
                        input logic [LW-1:0] y, input logic [AW-1:0] s, input bit c);
        @(negedge clk);
        desc_addr = a; desc_xlen = x; desc_ylen = y; desc_stride = s; desc_cyclic = c;
        desc_valid = 1'b1;
        @(posedge clk);
    endtask

    // Consume nb beats and compare each against the computed pattern.
    task automatic consume(input int nb, input logic [AW-1:0] st, input logic [AW-1:0] sd,
                           input int xl, input int yl, input bit cyc, input int stall_mod,
                           input bit drop_desc);
        int beats = (xl >> 2) + 1;
        int total = beats * (yl + 1);
        longint sa = st & ~32'h3;
        longint ss = sd & ~32'h3;
        int k = 0;
        int cyc_n = 0;
        bit first = 1;
        bit stalled = 0;
        logic [AW-1:0] held_addr = '0;
        logic held_last = 1'b0;
        bit saw_done = 0;
        while (k < nb && cyc_n < 2000) begin
            @(negedge clk);
            if (drop_desc) desc_valid = 1'b0;
            out_ready = (stall_mod == 0) ? 1'b1 : ((cyc_n % stall_mod) != 0);
            cyc_n++;
            if (done) saw_done = 1;
            if (first) begin
                chk(out_valid == 1'b1, "R3", "valid after accept", out_valid, 1);
                chk(desc_ready == 1'b0, "R2", "ready while busy", desc_ready, 0);
                first = 0;
            end
            if (stalled) begin
                chk(out_valid && out_addr == held_addr && out_last == held_last,
                    "R9", "hold under stall", out_addr, held_addr);
            end
            stalled = 0;
            if (out_valid && out_ready) begin
                int kk = k % total;
                longint l = kk / beats;
                longint b = kk % beats;
                longint exp = (sa + l * ss + b * BB) & 64'hFFFF_FFFF;
                chk(out_addr == AW'(exp), "R3 R4 R5", "beat address", out_addr, exp);
                chk(out_last == (kk == total - 1), "R6", "last marker", out_last, kk == total - 1);
                k++;
            end else if (out_valid) begin
                stalled = 1; held_addr = out_addr; held_last = out_last;
            end
        end
        chk(k == nb, "R4", "beats consumed", k, nb);
        if (!cyc) begin
            @(negedge clk);
            out_ready = 1'b0;
            desc_valid = 1'b0;
            chk(done == 1'b1, "R7", "done pulse", done, 1);
            chk(out_valid == 1'b0 && desc_ready == 1'b1, "R7", "idle with done",
                {out_valid, desc_ready}, 2'b01);
            @(negedge clk);
            chk(done == 1'b0, "R7", "done single cycle", done, 0);
            chk(out_valid == 1'b0, "R4", "no extra beat", out_valid, 0);
        end else begin
            @(negedge clk);
            out_ready = 1'b0;
            repeat (4) begin
                @(negedge clk);
                if (done) saw_done = 1;
            end
            chk(out_valid == 1'b1, "R8", "stream continues", out_valid, 1);
            chk(saw_done == 0, "R8", "no done in cyclic", saw_done, 0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(desc_ready == 1'b1, "R1", "ready after reset", desc_ready, 1);
        chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
    endtask

    task automatic t_single_beat();
        send(32'h40, 16'd0, 16'd0, 32'h0, 1'b0);
        consume(1, 32'h40, 32'h0, 0, 0, 1'b0, 0, 1'b1);
    endtask

    task automatic t_one_line();
        send(32'h1000, 16'd31, 16'd0, 32'h0, 1'b0);
        consume(8, 32'h1000, 32'h0, 31, 0, 1'b0, 0, 1'b1);
    endtask

    task automatic t_two_dim();
        send(32'h2000, 16'd15, 16'd3, 32'h100, 1'b0);
        consume(16, 32'h2000, 32'h100, 15, 3, 1'b0, 0, 1'b1);
    endtask

    task automatic t_backpressure();
        send(32'h3000, 16'd15, 16'd2, 32'h20, 1'b0);
        consume(12, 32'h3000, 32'h20, 15, 2, 1'b0, 3, 1'b1);
    endtask

    task automatic t_unaligned();
        // R10: 0x103 -> 0x100, stride 0x47 -> 0x44
        send(32'h103, 16'd7, 16'd2, 32'h47, 1'b0);
        consume(6, 32'h103, 32'h47, 7, 2, 1'b0, 0, 1'b1);
    endtask

    task automatic t_busy_ignored();
        send(32'h4000, 16'd11, 16'd1, 32'h80, 1'b0);
        @(negedge clk);
        // R2: offer a different descriptor while the first is running
        desc_addr = 32'hABC0; desc_xlen = 16'd3; desc_ylen = 16'd0;
        desc_stride = 32'h8; desc_cyclic = 1'b1;
        out_ready = 1'b0;
        chk(desc_ready == 1'b0, "R2", "busy refuses descriptor", desc_ready, 0);
        consume(6, 32'h4000, 32'h80, 11, 1, 1'b0, 2, 1'b0);
        desc_valid = 1'b0;
    endtask

    task automatic t_cyclic();
        send(32'h300, 16'd7, 16'd1, 32'h40, 1'b1);
        consume(11, 32'h300, 32'h40, 7, 1, 1'b1, 4, 1'b1);
        do_reset();
    endtask

    initial begin
        t_reset();
        t_single_beat();
        t_one_line();
        t_two_dim();
        t_backpressure();
        t_unaligned();
        t_busy_ignored();
        t_cyclic();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule